// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block keeps an asynchronous-strobe DRAM alive. It owes one refresh to the memory every fixed number of clock cycles and carries out each one as a CAS-before-RAS cycle, so the memory supplies the row from its own internal counter and no address is produced here. Owed refreshes accumulate in a bounded backlog, so the access controller can finish its own work before it hands the bus over. The backlog raises an urgent flag once it is full.

A low-power request moves the memory into self-refresh. The entry is a CAS-before-RAS cycle whose RAS stays low for a minimum hold time. The acknowledge is raised only after that hold. When the request is withdrawn, RAS goes high and the acknowledge is held through the exit recovery time. Because the refresh is distributed, no burst is needed after exit. Instead the backlog is emptied and the interval timer restarts. All times are counted in clock cycles and set by parameters.

The access controller sees a request/grant pair and a bus-ownership flag. While the flag is high, the RAS and CAS outputs of this block drive the memory. While it is low, those outputs sit at their inactive high level.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and right after reset, `ras_n`=1, `cas_n`=2'b11, and `bus_own`, `sleep_ack`, `ref_req` and `ref_urgent` are all 0.
- R2: One refresh is owed each `REFI_CYC` cycles. After reset release, `ref_req` is still 0 after `REFI_CYC`-1 clock edges and is 1 after `REFI_CYC` edges.
- R3: The backlog holds at most `PEND_DEPTH` owed refreshes. `ref_urgent` is 1 once the backlog reaches `PEND_DEPTH` (first after `PEND_DEPTH`*`REFI_CYC` edges). Intervals that expire while the backlog is full add nothing, so a held grant then yields exactly `PEND_DEPTH` refresh cycles.
- R4: A refresh starts on the first edge with `ref_gnt`=1 while idle, a refresh owed and `sleep_req`=0. Both CAS bits go low for `CSR_CYC` cycles with RAS high, and then RAS is low for `RAS_CYC` cycles.
- R5: In every refresh or self-refresh entry, both CAS bits stay low for exactly `CHR_CYC` cycles after RAS falls and are high for the rest of the RAS-low time.
- R6: After RAS rises at the end of a refresh, the bus stays owned with all strobes high for `RP_CYC` cycles. Then `bus_own` drops for at least one cycle.
- R7: Each refresh cycle removes one owed refresh. `ref_req` falls when nothing is owed and no sleep is requested.
- R8: While idle, `sleep_req`=1 raises `ref_req`. A grant then starts self-refresh entry instead of any owed refresh. `sleep_ack` rises exactly `SR_HOLD_CYC` cycles after RAS falls. While asleep, `ref_req` is 0.
- R9: RAS stays low while `sleep_req` remains 1. On the first edge that sees `sleep_req`=0 in the sleep state, RAS rises. `sleep_ack` stays 1 for `SR_EXIT_CYC` cycles with RAS high and falls together with `bus_own`.
- R10: If `sleep_req` is withdrawn during entry, the hold still completes. `sleep_ack` is then 1 for one cycle with RAS low, and the normal exit follows.
- R11: At self-refresh exit the backlog is emptied and the interval restarts. `ref_req` stays 0 for `REFI_CYC`-1 edges after `sleep_ack` falls and is 1 after `REFI_CYC` edges.
- R12: When `bus_own`=0, `ras_n`=1 and `cas_n`=2'b11. `sleep_ack`=1 only while `bus_own`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every time is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access controller hands over the bus; sampled only while idle |
| sleep_req | input | 1 | Low-power request: enter and hold self-refresh while 1 |
| ref_req | output | 1 | A refresh is owed, or a self-refresh entry is requested |
| ref_urgent | output | 1 | Backlog of owed refreshes is full |
| sleep_ack | output | 1 | Memory is in self-refresh (hold met) or still in exit recovery |
| bus_own | output | 1 | This block drives the strobes; the controller must stay off |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Both column strobes, active low, always driven together |

## Verification
A wrong phase counter or a state skipped shows up as a strobe pulse of the wrong length. The monitor measures the CAS setup, the RAS-low time, the CAS hold and the precharge tail of each pulse. It catches the error when that pulse's tail ends, within a few dozen cycles. A backlog that counts wrongly does not change any strobe. It shows only in the edge on which `ref_req` or `ref_urgent` rises, or in how many refresh pulses one held grant produces, so those are sampled on the exact edge. A timer or backlog that is not cleared at self-refresh exit shows up as `ref_req` rising early, inside the first interval after `sleep_ack` falls.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CBR_SETUP,
        SQ_CBR_LOW,
        SQ_CBR_PRECH,
        SQ_SR_SETUP,
        SQ_SR_HOLD,
        SQ_SR_STAY,
        SQ_SR_EXIT
    } seq_state_e;

    typedef struct packed {
        logic       ras_n;
        logic [1:0] cas_n;
        logic       own;
        logic       ack;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 2'b11, own: 1'b0, ack: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic in_sleep(input seq_state_e s);
        return (s == SQ_SR_SETUP) || (s == SQ_SR_HOLD) ||
               (s == SQ_SR_STAY)  || (s == SQ_SR_EXIT);
    endfunction

    // Successor of a timed phase once its count is used up.
    function automatic seq_state_e next_phase(input seq_state_e s);
        case (s)
            SQ_CBR_SETUP: return SQ_CBR_LOW;
            SQ_CBR_LOW:   return SQ_CBR_PRECH;
            SQ_SR_SETUP:  return SQ_SR_HOLD;
            SQ_SR_HOLD:   return SQ_SR_STAY;
            default:      return SQ_IDLE;
        endcase
    endfunction

    // Strobe levels for a phase; cas_hold marks the early part of a RAS-low phase.
    function automatic strobe_t decode(input seq_state_e s, input logic cas_hold);
        strobe_t o;
        o = STROBE_IDLE;
        case (s)
            SQ_CBR_SETUP, SQ_SR_SETUP: begin
                o.own   = 1'b1;
                o.cas_n = 2'b00;
            end
            SQ_CBR_LOW, SQ_SR_HOLD: begin
                o.own   = 1'b1;
                o.ras_n = 1'b0;
                o.cas_n = cas_hold ? 2'b00 : 2'b11;
            end
            SQ_SR_STAY: begin
                o.own   = 1'b1;
                o.ras_n = 1'b0;
                o.ack   = 1'b1;
            end
            SQ_CBR_PRECH: o.own = 1'b1;
            SQ_SR_EXIT: begin
                o.own = 1'b1;
                o.ack = 1'b1;
            end
            default: o = STROBE_IDLE;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
    parameter int unsigned REFI_CYC   = 3900,
    parameter int unsigned PEND_DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic take,
    output logic pend_nz,
    output logic urgent
);
    localparam int unsigned TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam int unsigned PW = $clog2(PEND_DEPTH + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(REFI_CYC - 1);
    localparam logic [PW-1:0] PEND_FULL = PW'(PEND_DEPTH);

    logic [TW-1:0] tmr;
    logic [PW-1:0] pend;
    logic [PW-1:0] pend_n;
    logic          tick;

    assign tick = (tmr == TMR_LAST);

    always_comb begin
        pend_n = pend;
        unique case ({tick, take})
            2'b10:   if (pend != PEND_FULL) pend_n = pend + PW'(1);
            2'b01:   pend_n = pend - PW'(1);
            default: pend_n = pend;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tmr  <= '0;
            pend <= '0;
        end else begin
            tmr  <= tick ? '0 : tmr + TW'(1);
            pend <= pend_n;
        end
    end

    assign pend_nz = (pend != '0);
    assign urgent  = (pend == PEND_FULL);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        pend <= PEND_FULL);

    assert_full_saturates_R3: assert property (@(posedge clk) disable iff (rst)
        (pend == PEND_FULL && tick && !take && !clear) |=> pend == PEND_FULL);

    assert_take_only_owed_R7: assert property (@(posedge clk) disable iff (rst)
        (take && !clear) |-> pend != '0);

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
    import refsched_pkg::*;
#(
    parameter int unsigned CSR_CYC     = 2,
    parameter int unsigned CHR_CYC     = 2,
    parameter int unsigned RAS_CYC     = 13,
    parameter int unsigned RP_CYC      = 8,
    parameter int unsigned SR_HOLD_CYC = 25000,
    parameter int unsigned SR_EXIT_CYC = 21
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_cbr,
    input  logic    start_sr,
    input  logic    sleep_req,
    output strobe_t strb,
    output logic    idle,
    output logic    asleep
);
    localparam int unsigned MAXD = max2(max2(max2(CSR_CYC, CHR_CYC), max2(RAS_CYC, RP_CYC)),
                                        max2(SR_HOLD_CYC, SR_EXIT_CYC));
    localparam int unsigned CW = $clog2(MAXD + 1);

    seq_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n, last;
    logic          done;
    strobe_t       strb_n;

    always_comb begin
        case (state)
            SQ_CBR_SETUP, SQ_SR_SETUP: last = CW'(CSR_CYC - 1);
            SQ_CBR_LOW:                last = CW'(RAS_CYC - 1);
            SQ_CBR_PRECH:              last = CW'(RP_CYC - 1);
            SQ_SR_HOLD:                last = CW'(SR_HOLD_CYC - 1);
            SQ_SR_EXIT:                last = CW'(SR_EXIT_CYC - 1);
            default:                   last = '0;
        endcase
        done = (cnt == last);
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt + CW'(1);
        case (state)
            SQ_IDLE: begin
                cnt_n = '0;
                if (start_sr)       state_n = SQ_SR_SETUP;
                else if (start_cbr) state_n = SQ_CBR_SETUP;
            end
            SQ_SR_STAY: begin
                cnt_n = '0;
                if (!sleep_req) state_n = SQ_SR_EXIT;
            end
            default: begin
                if (done) begin
                    cnt_n   = '0;
                    state_n = next_phase(state);
                end
            end
        endcase
        strb_n = decode(state_n, cnt_n < CW'(CHR_CYC));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            strb  <= STROBE_IDLE;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            strb  <= strb_n;
        end
    end

    assign idle   = (state == SQ_IDLE);
    assign asleep = in_sleep(state);

    // Checker-only count of consecutive RAS-low cycles.
    logic [CW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || strb.ras_n)        low_run <= '0;
        else if (low_run != CW'(MAXD)) low_run <= low_run + CW'(1);
    end

    assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |-> (strb.cas_n == 2'b00) && ($past(strb.cas_n) == 2'b00));

    assert_ack_after_hold_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ack) |-> !strb.ras_n && (low_run >= CW'(SR_HOLD_CYC - 1)));

    assert_exit_ras_high_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ack) |-> strb.ras_n && $past(strb.ras_n));

    assert_idle_released_R12: assert property (@(posedge clk) disable iff (rst)
        !strb.own |-> strb.ras_n && (strb.cas_n == 2'b11) && !strb.ack);

    assert_ras_rise_cas_high_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ras_n) |-> strb.cas_n == 2'b11);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsched_pkg::*;
#(
    parameter int unsigned REFI_CYC    = 3900,
    parameter int unsigned PEND_DEPTH  = 8,
    parameter int unsigned CSR_CYC     = 2,
    parameter int unsigned CHR_CYC     = 2,
    parameter int unsigned RAS_CYC     = 13,
    parameter int unsigned RP_CYC      = 8,
    parameter int unsigned SR_HOLD_CYC = 25000,
    parameter int unsigned SR_EXIT_CYC = 21
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_gnt,
    input  logic       sleep_req,
    output logic       ref_req,
    output logic       ref_urgent,
    output logic       sleep_ack,
    output logic       bus_own,
    output logic       ras_n,
    output logic [1:0] cas_n
);
    strobe_t strb;
    logic    seq_idle, seq_asleep, pend_nz, start_cbr, start_sr;

    assign start_sr  = seq_idle && ref_gnt && sleep_req;
    assign start_cbr = seq_idle && ref_gnt && !sleep_req && pend_nz;

    refsched_backlog #(
        .REFI_CYC  (REFI_CYC),
        .PEND_DEPTH(PEND_DEPTH)
    ) u_backlog (
        .clk    (clk),
        .rst    (rst),
        .clear  (seq_asleep),
        .take   (start_cbr),
        .pend_nz(pend_nz),
        .urgent (ref_urgent)
    );

    refsched_seq #(
        .CSR_CYC    (CSR_CYC),
        .CHR_CYC    (CHR_CYC),
        .RAS_CYC    (RAS_CYC),
        .RP_CYC     (RP_CYC),
        .SR_HOLD_CYC(SR_HOLD_CYC),
        .SR_EXIT_CYC(SR_EXIT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_cbr(start_cbr),
        .start_sr (start_sr),
        .sleep_req(sleep_req),
        .strb     (strb),
        .idle     (seq_idle),
        .asleep   (seq_asleep)
    );

    assign ref_req   = pend_nz || (sleep_req && seq_idle);
    assign sleep_ack = strb.ack;
    assign bus_own   = strb.own;
    assign ras_n     = strb.ras_n;
    assign cas_n     = strb.cas_n;

    assert_no_req_asleep_R8: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> !ref_req);

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int REFI  = 400;
    localparam int DEPTH = 4;
    localparam int CSR   = 2;
    localparam int CHR   = 2;
    localparam int RASC  = 13;
    localparam int RP    = 8;
    localparam int HOLD  = 300;
    localparam int EXITC = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic sleep_req = 1'b0;
    logic ref_req, ref_urgent, sleep_ack, bus_own, ras_n;
    logic [1:0] cas_n;

    int errors = 0;
    int checks = 0;
    int records_done = 0;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .REFI_CYC(REFI), .PEND_DEPTH(DEPTH), .CSR_CYC(CSR), .CHR_CYC(CHR),
        .RAS_CYC(RASC), .RP_CYC(RP), .SR_HOLD_CYC(HOLD), .SR_EXIT_CYC(EXITC)
    ) u_dut (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .sleep_req(sleep_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .sleep_ack(sleep_ack),
        .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n)
    );

    typedef struct {
        int    csr;
        int    low;
        int    chr;
        int    ackd;
        int    tail;
        int    tack;
        string tag;
    } pulse_t;

    pulse_t exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push_cbr();
        pulse_t p;
        p = '{csr: CSR, low: RASC, chr: CHR, ackd: 0, tail: RP, tack: 0,
              tag: "R4 R5 R6 refresh pulse"};
        exp_q.push_back(p);
    endtask

    task automatic push_sr(input int stay);
        pulse_t p;
        p = '{csr: CSR, low: HOLD + stay, chr: CHR, ackd: HOLD, tail: EXITC, tack: EXITC,
              tag: "R8 R9 R10 self-refresh pulse"};
        exp_q.push_back(p);
    endtask

    // Monitor: measures each RAS pulse and compares it with the queue.
    int m_phase = 0;
    int m_csr = 0, m_low = 0, m_chr = 0, m_ackd = 0, m_tail = 0, m_tack = 0;
    bit m_got = 1'b0;

    task automatic finish_pulse();
        pulse_t e;
        records_done++;
        if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected strobe pulse", m_low, 0);
        end else begin
            e = exp_q.pop_front();
            check(m_csr == e.csr, {e.tag, " CAS setup"}, m_csr, e.csr);
            check(m_low == e.low, {e.tag, " RAS low"}, m_low, e.low);
            check(m_chr == e.chr, {e.tag, " CAS hold"}, m_chr, e.chr);
            check(m_ackd == e.ackd, {e.tag, " ack delay"}, m_ackd, e.ackd);
            check(m_tail == e.tail, {e.tag, " tail"}, m_tail, e.tail);
            check(m_tack == e.tack, {e.tag, " ack tail"}, m_tack, e.tack);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!bus_own)
                check(ras_n && cas_n == 2'b11 && !sleep_ack, "R12 idle strobes",
                      {29'd0, ras_n, cas_n}, 7);
            case (m_phase)
                0: begin
                    if (ras_n) begin
                        if (bus_own && cas_n == 2'b00) m_csr++;
                        else m_csr = 0;
                    end else begin
                        m_phase = 1;
                        m_low = 1;
                        m_chr = (cas_n == 2'b00) ? 1 : 0;
                        m_ackd = 0;
                        m_got = 1'b0;
                    end
                end
                1: begin
                    if (!ras_n) begin
                        if (sleep_ack && !m_got) begin
                            m_ackd = m_low;
                            m_got = 1'b1;
                        end
                        m_low++;
                        if (cas_n == 2'b00) m_chr++;
                    end else begin
                        m_phase = 2;
                        m_tail = bus_own ? 1 : 0;
                        m_tack = sleep_ack ? 1 : 0;
                    end
                end
                default: begin
                    if (bus_own && ras_n) begin
                        m_tail++;
                        if (sleep_ack) m_tack++;
                    end else begin
                        finish_pulse();
                        m_phase = 0;
                        m_csr = 0;
                    end
                end
            endcase
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(ras_n && cas_n == 2'b11, "R1 reset strobes", {30'd0, cas_n}, 3);
        check(!bus_own && !sleep_ack, "R1 reset own/ack", {30'd0, bus_own, sleep_ack}, 0);
        check(!ref_req && !ref_urgent, "R1 reset req/urgent", {30'd0, ref_req, ref_urgent}, 0);
        rst = 1'b0;

        // R2: first refresh owed after exactly REFI edges
        repeat (REFI - 1) @(negedge clk);
        check(!ref_req, "R2 req before interval", ref_req, 0);
        @(negedge clk);
        check(ref_req, "R2 req at interval", ref_req, 1);

        // R3: backlog fills to DEPTH, then saturates
        repeat ((DEPTH - 1) * REFI - 1) @(negedge clk);
        check(!ref_urgent, "R3 urgent before full", ref_urgent, 0);
        @(negedge clk);
        check(ref_urgent, "R3 urgent when full", ref_urgent, 1);
        repeat (2 * REFI) @(negedge clk);
        check(ref_urgent, "R3 urgent stays while saturated", ref_urgent, 1);

        // R3/R6/R7: held grant drains exactly DEPTH refreshes back to back
        for (int i = 0; i < DEPTH; i++) push_cbr();
        ref_gnt = 1'b1;
        while (ref_req) @(negedge clk);
        ref_gnt = 1'b0;
        while (bus_own) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R3 backlog drained count", records_done, DEPTH);
        check(records_done == DEPTH, "R7 one refresh per owed", records_done, DEPTH);
        check(!ref_req && !ref_urgent, "R7 req drops when empty", ref_req, 0);

        // R4/R2: single distributed refresh
        while (!ref_req) @(negedge clk);
        push_cbr();
        ref_gnt = 1'b1;
        while (!bus_own) @(negedge clk);
        ref_gnt = 1'b0;
        while (bus_own) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0 && !ref_req, "R4 single refresh done", exp_q.size(), 0);

        // R8/R9/R11: sleep takes priority over an owed refresh
        while (!ref_req) @(negedge clk);
        push_sr(6);
        sleep_req = 1'b1;
        ref_gnt = 1'b1;
        while (!sleep_ack) @(negedge clk);
        ref_gnt = 1'b0;
        check(!ref_req, "R8 no request while asleep", ref_req, 0);
        check(!ras_n, "R9 RAS low while asleep", ras_n, 0);
        repeat (5) @(negedge clk);
        sleep_req = 1'b0;
        while (sleep_ack) @(negedge clk);
        check(!bus_own, "R9 bus released with ack", bus_own, 0);
        repeat (REFI - 1) @(negedge clk);
        check(!ref_req, "R11 backlog cleared after exit", ref_req, 0);
        @(negedge clk);
        check(ref_req, "R11 interval restarted at exit", ref_req, 1);

        // R10: request withdrawn during entry
        push_sr(1);
        sleep_req = 1'b1;
        ref_gnt = 1'b1;
        while (!bus_own) @(negedge clk);
        sleep_req = 1'b0;
        ref_gnt = 1'b0;
        while (!sleep_ack) @(negedge clk);
        check(!ras_n, "R10 ack pulses with RAS low", ras_n, 0);
        while (sleep_ack) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R10 all pulses seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule